// File: doc/BRIEF.md
# Complex Pin Group Timer/Counter Engine

This block is a timing engine that serves one group of pins on a general-purpose I/O port. It holds a running counter together with period and threshold values, and it runs one timing function at a time. It can generate a pulse-width-modulated waveform, fire a single pulse of programmed length, or act as a free-running interval timer whose count firmware can read. Only one member of the pin group is bound to the engine at a time, and a pin index field selects it.

Counting advances on a tick. In fast mode a tick occurs on every clock cycle. In slow mode a tick occurs on one cycle out of every `SLOW_DIV` cycles. The choice comes from a select bit and is built as a synchronous enable, so the engine never gates the clock. Writes to the period and threshold registers go to shadow registers. These values are adopted at the next wrap, so the output waveform never glitches. The engine raises a one-cycle interrupt when an interval timer wraps and when a single pulse ends.

Top module: `cgpio_timer_group`

## Requirements
- R1: After synchronous reset, `pin_oe`, `pin_out`, `irq` and `timer_val` are all zero.
- R2: Writing address 0 loads the control word. Its fields are: bits [1:0] mode (00 interval timer, 01 PWM, 10 single pulse, 11 off), bit 2 fast clock select, bits [IDX_W+2:3] pin index, and bit IDX_W+3 start. In mode off, `pin_oe`, `pin_out` and `timer_val` stay zero and `irq` stays low.
- R3: In PWM and single-pulse modes, only the `pin_oe` bit at the selected index is high. `pin_out` can be high only at that bit. In timer and off modes, `pin_oe` is all zero.
- R4: In PWM mode the counter runs from 0 up to the period and then wraps. The output is high while the counter is below the threshold. Over one period the output is therefore high for min(threshold, period+1) ticks.
- R5: In interval timer mode, `irq` pulses for one cycle at every wrap. Pulses are spaced period+1 ticks apart.
- R6: In single-pulse mode, a control write with the start bit set drives the output high for exactly threshold ticks. The output then returns low and the engine goes idle. `irq` pulses in the first cycle the output is low.
- R7: A start with a threshold of 0 produces no pulse and no interrupt.
- R8: With the fast select bit at 1, a tick occurs every clock cycle. With it at 0, a tick occurs once every `SLOW_DIV` cycles.
- R9: Writes to address 1 (period) and address 2 (threshold) take effect only at the next wrap or at the next control write. A control write restarts the counter from 0 and adopts any pending values.
- R10: `timer_val` presents the running count. It reads 0 in the cycle after a control write and rises by one per tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 control, 1 period, 2 threshold) |
| wr_data | input | CNT_W | Write data |
| pin_out | output | GRP_N | Output value for each pin of the group |
| pin_oe | output | GRP_N | Output enable for each pin of the group |
| timer_val | output | CNT_W | Running count |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The bench builds the engine with an 8-bit counter, a group of eight pins and a slow divide of 4. With these values, a full PWM period and a slow-mode interval of 12 cycles can each be measured edge by edge within a few dozen cycles. The vector table sweeps several period and threshold pairs across different pin indices. The pairs include a period of 0 and a threshold above the period. Directed tests cover the deferred threshold update, the single pulse with a threshold of 0, and the off mode.

// File: rtl/cgpio_pkg.sv
package cgpio_pkg;

    typedef enum logic [1:0] {
        MODE_TIMER   = 2'b00,
        MODE_PWM     = 2'b01,
        MODE_ONESHOT = 2'b10,
        MODE_OFF     = 2'b11
    } cg_mode_e;

    localparam logic [1:0] ADDR_CTRL   = 2'd0;
    localparam logic [1:0] ADDR_PERIOD = 2'd1;
    localparam logic [1:0] ADDR_THRESH = 2'd2;

    localparam int CTRL_FAST_BIT = 2;
    localparam int CTRL_IDX_LSB  = 3;

    function automatic logic mode_drives_pin(cg_mode_e m);
        return (m == MODE_PWM) || (m == MODE_ONESHOT);
    endfunction

endpackage

// File: rtl/cgpio_prescaler.sv
module cgpio_prescaler #(
    parameter int SLOW_DIV = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic fast,
    output logic tick
);
    localparam int PW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(SLOW_DIV - 1);

    logic [PW-1:0] div_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
        end else if (div_q == LAST) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    assign tick = fast || (div_q == LAST);
endmodule

// File: rtl/cgpio_engine.sv
module cgpio_engine
    import cgpio_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  cg_mode_e         mode,
    input  logic             restart,
    input  logic             start_os,
    input  logic [CNT_W-1:0] per_sh,
    input  logic [CNT_W-1:0] thr_sh,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] act_per,
    output logic             busy,
    output logic             wave,
    output logic             irq
);
    logic [CNT_W-1:0] act_thr;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            act_per <= '0;
            act_thr <= '0;
            busy    <= 1'b0;
            irq     <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (restart) begin
                cnt     <= '0;
                act_per <= per_sh;
                act_thr <= thr_sh;
                busy    <= start_os && (thr_sh != '0);
            end else if (tick) begin
                unique case (mode)
                    MODE_TIMER, MODE_PWM: begin
                        if (cnt >= act_per) begin
                            cnt     <= '0;
                            act_per <= per_sh;
                            act_thr <= thr_sh;
                            irq     <= (mode == MODE_TIMER);
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    MODE_ONESHOT: begin
                        if (busy) begin
                            if (cnt == act_thr - 1'b1) begin
                                busy <= 1'b0;
                                irq  <= 1'b1;
                            end else begin
                                cnt <= cnt + 1'b1;
                            end
                        end
                    end
                    default: cnt <= '0;
                endcase
            end
        end
    end

    always_comb begin
        unique case (mode)
            MODE_PWM:     wave = (cnt < act_thr);
            MODE_ONESHOT: wave = busy;
            default:      wave = 1'b0;
        endcase
    end
endmodule

// File: rtl/cgpio_pin_steer.sv
module cgpio_pin_steer #(
    parameter int GRP_N = 8,
    parameter int IDX_W = 3
) (
    input  logic             en,
    input  logic [IDX_W-1:0] sel,
    input  logic             wave,
    output logic [GRP_N-1:0] pin_out,
    output logic [GRP_N-1:0] pin_oe
);
    for (genvar i = 0; i < GRP_N; i++) begin : g_pin
        assign pin_oe[i]  = en && (sel == IDX_W'(i));
        assign pin_out[i] = en && (sel == IDX_W'(i)) && wave;
    end
endmodule

// File: rtl/cgpio_timer_group.sv
module cgpio_timer_group
    import cgpio_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int GRP_N    = 8,
    parameter int SLOW_DIV = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    output logic [GRP_N-1:0] pin_out,
    output logic [GRP_N-1:0] pin_oe,
    output logic [CNT_W-1:0] timer_val,
    output logic             irq
);
    localparam int IDX_W     = (GRP_N > 1) ? $clog2(GRP_N) : 1;
    localparam int START_BIT = CTRL_IDX_LSB + IDX_W;

    cg_mode_e         mode_q;
    logic             fast_q;
    logic [IDX_W-1:0] sel_q;
    logic [CNT_W-1:0] per_sh, thr_sh, act_per;
    logic             tick, busy, wave, ctl_wr, start_os;

    assign ctl_wr   = wr_en && (wr_addr == ADDR_CTRL);
    assign start_os = ctl_wr && wr_data[START_BIT]
                      && (cg_mode_e'(wr_data[1:0]) == MODE_ONESHOT);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_OFF;
            fast_q <= 1'b0;
            sel_q  <= '0;
            per_sh <= '0;
            thr_sh <= '0;
        end else if (wr_en) begin
            unique case (wr_addr)
                ADDR_CTRL: begin
                    mode_q <= cg_mode_e'(wr_data[1:0]);
                    fast_q <= wr_data[CTRL_FAST_BIT];
                    sel_q  <= wr_data[CTRL_IDX_LSB +: IDX_W];
                end
                ADDR_PERIOD: per_sh <= wr_data;
                ADDR_THRESH: thr_sh <= wr_data;
                default: ;
            endcase
        end
    end

    cgpio_prescaler #(.SLOW_DIV(SLOW_DIV)) u_psc (
        .clk(clk), .rst(rst), .fast(fast_q), .tick(tick)
    );

    cgpio_engine #(.CNT_W(CNT_W)) u_eng (
        .clk(clk), .rst(rst), .tick(tick), .mode(mode_q),
        .restart(ctl_wr), .start_os(start_os),
        .per_sh(per_sh), .thr_sh(thr_sh),
        .cnt(timer_val), .act_per(act_per), .busy(busy),
        .wave(wave), .irq(irq)
    );

    cgpio_pin_steer #(.GRP_N(GRP_N), .IDX_W(IDX_W)) u_steer (
        .en(mode_drives_pin(mode_q)), .sel(sel_q), .wave(wave),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );
endmodule

// File: rtl/cgpio_timer_chk.sv
module cgpio_timer_chk
    import cgpio_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int GRP_N = 8
) (
    input logic             clk,
    input logic             rst,
    input cg_mode_e         mode,
    input logic             fast,
    input logic             tick,
    input logic             ctl_wr,
    input logic             busy,
    input logic             irq,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] act_per,
    input logic [GRP_N-1:0] pin_out,
    input logic [GRP_N-1:0] pin_oe
);
    AST_ONE_PIN: assert property (@(posedge clk) disable iff (rst)
        $onehot0(pin_oe)); // R3

    AST_OUT_ONLY_BOUND: assert property (@(posedge clk) disable iff (rst)
        (pin_out & ~pin_oe) == '0); // R3

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_OFF) |-> (cnt == '0 && pin_oe == '0 && !irq)); // R2

    AST_CNT_IN_PERIOD: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_PWM || mode == MODE_TIMER) |-> (cnt <= act_per)); // R4

    AST_SLOW_SPACING: assert property (@(posedge clk) disable iff (rst)
        (tick && !fast) |=> (!tick || fast)); // R8

    AST_PULSE_END_IRQ: assert property (@(posedge clk) disable iff (rst)
        ($fell(busy) && !$past(ctl_wr)) |-> irq); // R6
endmodule

bind cgpio_timer_group cgpio_timer_chk #(.CNT_W(CNT_W), .GRP_N(GRP_N)) u_chk (
    .clk(clk), .rst(rst), .mode(mode_q), .fast(fast_q), .tick(tick),
    .ctl_wr(ctl_wr), .busy(busy), .irq(irq), .cnt(timer_val),
    .act_per(act_per), .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/sim_cgpio_timer_group.sv
module sim_cgpio_timer_group;
    localparam int CNT_W = 8;
    localparam int GRP_N = 8;
    localparam int SDIV  = 4;
    localparam int NV    = 6;
    localparam int VP [NV] = '{9, 4, 0, 7, 15, 3};
    localparam int VT [NV] = '{3, 0, 1, 8, 20, 2};
    localparam int VS [NV] = '{0, 3, 7, 5, 1, 6};

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             wr_en = 1'b0;
    logic [1:0]       wr_addr = '0;
    logic [CNT_W-1:0] wr_data = '0;
    logic [GRP_N-1:0] pin_out, pin_oe;
    logic [CNT_W-1:0] timer_val;
    logic             irq;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    cgpio_timer_group #(.CNT_W(CNT_W), .GRP_N(GRP_N), .SLOW_DIV(SDIV)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pin_out(pin_out), .pin_oe(pin_oe), .timer_val(timer_val), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = CNT_W'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic int ctrl(input int mode, input int fast, input int pin, input int start);
        return mode | (fast << 2) | (pin << 3) | (start << 6);
    endfunction

    task automatic irq_gap(output int gap);
        int guard = 0;
        while (!irq && guard < 500) begin @(negedge clk); guard++; end
        gap = 0;
        do begin @(negedge clk); gap++; end while (!irq && gap < 500);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++; n_run++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : main
        int highs, gap, expv;
        bit seen;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(pin_oe == 0 && pin_out == 0 && irq == 0 && timer_val == 0, "R1", int'(pin_oe), 0);
        rst = 1'b0;

        // R4 / R3 vector table: PWM high count per period and pin binding
        for (int i = 0; i < NV; i++) begin
            wr(2'd1, VP[i]);
            wr(2'd2, VT[i]);
            wr(2'd0, ctrl(1, 1, VS[i], 0));
            highs = 0;
            for (int k = 0; k <= VP[i]; k++) begin
                if (pin_out[VS[i]]) highs++;
                @(negedge clk);
            end
            expv = (VT[i] < VP[i] + 1) ? VT[i] : VP[i] + 1;
            check(highs == expv, "R4", highs, expv);
            check(pin_oe == GRP_N'(1 << VS[i]), "R3", int'(pin_oe), 1 << VS[i]);
        end

        // R9 threshold deferred to next wrap
        wr(2'd1, 9);
        wr(2'd2, 3);
        wr(2'd0, ctrl(1, 1, 2, 0));
        highs = 0;
        for (int k = 0; k < 10; k++) begin
            if (pin_out[2]) highs++;
            if (k == 5) begin
                wr_en = 1'b1; wr_addr = 2'd2; wr_data = 8'd7;
            end else begin
                wr_en = 1'b0;
            end
            @(negedge clk);
        end
        wr_en = 1'b0;
        check(highs == 3, "R9 old threshold held", highs, 3);
        highs = 0;
        for (int k = 0; k < 10; k++) begin
            if (pin_out[2]) highs++;
            @(negedge clk);
        end
        check(highs == 7, "R9 new threshold at wrap", highs, 7);

        // R10 running count; R5 interval timer
        wr(2'd1, 5);
        wr(2'd0, ctrl(0, 1, 0, 0));
        check(timer_val == 0, "R10 after restart", int'(timer_val), 0);
        check(pin_oe == 0, "R3 timer no pin", int'(pin_oe), 0);
        repeat (3) @(negedge clk);
        check(timer_val == 3, "R10 counting", int'(timer_val), 3);
        irq_gap(gap);
        check(gap == 6, "R5 fast interval", gap, 6);
        @(negedge clk);
        check(irq == 0, "R5 single cycle pulse", int'(irq), 0);

        // R8 slow clock select
        wr(2'd1, 2);
        wr(2'd0, ctrl(0, 0, 0, 0));
        irq_gap(gap);
        check(gap == 3 * SDIV, "R8 slow interval", gap, 3 * SDIV);

        // R6 single pulse
        wr(2'd2, 5);
        wr(2'd0, ctrl(2, 1, 4, 1));
        highs = 0;
        while (pin_out[4] && highs < 100) begin highs++; @(negedge clk); end
        check(highs == 5, "R6 pulse length", highs, 5);
        check(irq == 1, "R6 irq at end", int'(irq), 1);
        @(negedge clk);
        check(irq == 0 && pin_out == 0, "R6 idle after", int'(irq), 0);

        // R7 threshold zero start
        wr(2'd2, 0);
        wr(2'd0, ctrl(2, 1, 4, 1));
        seen = 1'b0;
        for (int k = 0; k < 10; k++) begin
            if (irq || pin_out != 0) seen = 1'b1;
            @(negedge clk);
        end
        check(!seen, "R7 no pulse no irq", int'(seen), 0);

        // R2 off mode
        wr(2'd1, 3);
        wr(2'd0, ctrl(3, 1, 1, 1));
        seen = 1'b0;
        for (int k = 0; k < 12; k++) begin
            if (irq || pin_oe != 0 || pin_out != 0 || timer_val != 0) seen = 1'b1;
            @(negedge clk);
        end
        check(!seen, "R2 off mode quiet", int'(seen), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule